// File: doc/BRIEF.md
# Cross-Clock Machine Timer

A 64-bit machine timer split over two clock domains. The time counter lives on a free-running reference clock that has no fixed relation to the processor clock. The compare register and the interrupt logic live on the processor clock. The processor reaches the timer through a 32-bit register port. Writes are posted with a strobe. Reads use a request followed by a one-cycle valid pulse. A level interrupt output stays high while time has reached the compare value.

Every transfer of time data between the domains uses a four-phase request/acknowledge handshake, with a two-flop synchronizer on each control bit. A time write holds its data and target half steady in the processor domain until the reference domain has applied it, and the block signals busy for the whole exchange. A snapshot loop runs all the time and copies the full 64-bit count into the processor domain. That copy drives the interrupt comparator. A time read waits for a snapshot that starts after the request. The count is always captured whole in one reference cycle, so the two halves of one sample never tear.

Top module: `xclk_mtimer`

## Requirements
- R1: After reset: time counts up from zero, both compare halves read 0xFFFFFFFF, `irq_o`, `busy_o` and `rd_valid_o` are low, and a high-half time read returns 0.
- R2: Time cannot be stopped. It increases by exactly one on every reference-clock edge that applies no write. Two successive low-half reads therefore return increasing values, and their difference is no larger than the number of reference edges between them.
- R3: An accepted write to either time half raises `busy_o` from the next cycle until the crossing handshake completes. While `busy_o` is high, `wr_en_i` and `rd_req_i` are ignored: no register changes and no `rd_valid_o` results. A read request in the same cycle as a write is dropped.
- R4: Select encoding for `wr_sel_i` and `rd_sel_i`: bit 1 is 0 for time and 1 for compare; bit 0 is 0 for the low half (bits 31:0) and 1 for the high half (bits 63:32). A write to one half leaves the other half unchanged; for time, the other half keeps counting.
- R5: Compare is a plain register that changes only when written. A compare read returns exactly the last value written to that half, with `rd_valid_o` one cycle after the request.
- R6: A low-half time read completes after a crossing, using a snapshot taken after the request. Its value is at least the value of any time write completed before the request, and at most that value plus the reference edges elapsed since the write.
- R7: A high-half time read returns bits 63:32 of the same 64-bit sample as the most recent low-half read, with `rd_valid_o` one cycle after the request. A low/high pair read across a low-half wrap is therefore consistent.
- R8: `irq_o` is high while the processor-side copy of time is at or above compare (64-bit unsigned). The copy is refreshed continuously. The interrupt falls within two cycles of a compare write that places compare above the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Processor-domain asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference clock for the time counter |
| ref_rst_ni | input | 1 | Reference-domain asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target register and half |
| wr_data_i | input | DATA_W | Write data |
| rd_req_i | input | 1 | Read request strobe |
| rd_sel_i | input | 2 | Read target register and half |
| rd_valid_o | output | 1 | One-cycle pulse marking `rd_data_o` valid |
| rd_data_o | output | DATA_W | Read data |
| busy_o | output | 1 | Crossing in flight; new strobes are refused |
| irq_o | output | 1 | Timer interrupt, level |

## Verification
The assertions assume that both resets are asserted together and held for several cycles of both clocks. They also assume that the select and data inputs are meaningful only in a cycle that carries a strobe. The crossing checks require nothing about the ratio of the two clocks, only that both keep running. The stimulus drives one strobe per cycle at the falling processor edge and normally waits for `busy_o` to fall before the next strobe. It breaks that rule on purpose only in the refused-strobe case. It uses a reference clock with a period of 17 ns against 5 ns, so handshake edges fall at changing phases. Time results are checked against windows built from a count of reference edges kept in the bench.

// File: rtl/xmt_pkg.sv
`timescale 1ns/1ps
package xmt_pkg;
  typedef enum logic [1:0] {
    SEL_TIME_LO = 2'b00,
    SEL_TIME_HI = 2'b01,
    SEL_CMP_LO  = 2'b10,
    SEL_CMP_HI  = 2'b11
  } reg_sel_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'b00,
    HS_REQ  = 2'b01,
    HS_REL  = 2'b10
  } hs_state_e;
endpackage

// File: rtl/xmt_sync.sv
`timescale 1ns/1ps
module xmt_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/xmt_ref_domain.sv
`timescale 1ns/1ps
module xmt_ref_domain #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TIME_W     = 2 * DATA_W
) (
  input  logic              ref_clk_i,
  input  logic              ref_rst_ni,
  input  logic              wr_req_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ack_o,
  input  logic              snap_req_i,
  output logic              snap_ack_o,
  output logic [TIME_W-1:0] snap_o
);
  logic wr_req_s, snap_req_s;
  logic wr_req_d, snap_req_d;
  logic wr_apply, snap_take;
  logic [TIME_W-1:0] time_q, time_inc, time_nxt, snap_q;

  xmt_sync #(.STAGES(SYNC_STAGES)) u_wr_req_sync (
    .clk_i(ref_clk_i), .rst_ni(ref_rst_ni), .d_i(wr_req_i), .q_o(wr_req_s));
  xmt_sync #(.STAGES(SYNC_STAGES)) u_snap_req_sync (
    .clk_i(ref_clk_i), .rst_ni(ref_rst_ni), .d_i(snap_req_i), .q_o(snap_req_s));

  // rising edge of each synchronized request
  assign wr_apply  = wr_req_s & ~wr_req_d;
  assign snap_take = snap_req_s & ~snap_req_d;
  assign time_inc  = time_q + TIME_W'(1);

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign time_nxt[h*DATA_W +: DATA_W] =
      (wr_apply && (wr_hi_i == 1'(h))) ? wr_data_i : time_inc[h*DATA_W +: DATA_W];
  end

  always_ff @(posedge ref_clk_i or negedge ref_rst_ni) begin
    if (!ref_rst_ni) begin
      wr_req_d   <= 1'b0;
      snap_req_d <= 1'b0;
      time_q     <= '0;
      snap_q     <= '0;
    end else begin
      wr_req_d   <= wr_req_s;
      snap_req_d <= snap_req_s;
      time_q     <= time_nxt;
      if (snap_take) snap_q <= time_q;
    end
  end

  // ack echoes the request one cycle after it took effect
  assign wr_ack_o   = wr_req_d;
  assign snap_ack_o = snap_req_d;
  assign snap_o     = snap_q;

  AST_TIME_STEP: assert property (@(posedge ref_clk_i) disable iff (!ref_rst_ni)
    !wr_apply |=> time_q == $past(time_q) + TIME_W'(1)); // R2
  AST_SNAP_STABLE: assert property (@(posedge ref_clk_i) disable iff (!ref_rst_ni)
    (snap_ack_o && $past(snap_ack_o)) |-> $stable(snap_q)); // R7
endmodule

// File: rtl/xmt_cmp_irq.sv
`timescale 1ns/1ps
module xmt_cmp_irq #(
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned TIME_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] cmp_o,
  output logic              irq_o
);
  logic [TIME_W-1:0] cmp_q, cmp_nxt;
  logic irq_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign cmp_nxt[h*DATA_W +: DATA_W] =
      (we_i && (hi_i == 1'(h))) ? data_i : cmp_q[h*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
      irq_q <= 1'b0;
    end else begin
      cmp_q <= cmp_nxt;
      irq_q <= (time_i >= cmp_q);
    end
  end

  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  AST_CMP_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cmp_q)); // R5
endmodule

// File: rtl/xmt_cpu_port.sv
`timescale 1ns/1ps
module xmt_cpu_port
  import xmt_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TIME_W     = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  input  logic [1:0]        rd_sel_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  input  logic [TIME_W-1:0] cmp_i,
  output logic              cmp_we_o,
  output logic              cmp_hi_o,
  output logic [DATA_W-1:0] cmp_data_o,
  output logic [TIME_W-1:0] time_copy_o,
  output logic              x_wr_req_o,
  output logic              x_wr_hi_o,
  output logic [DATA_W-1:0] x_wr_data_o,
  input  logic              x_wr_ack_i,
  output logic              x_snap_req_o,
  input  logic              x_snap_ack_i,
  input  logic [TIME_W-1:0] x_snap_i
);
  reg_sel_e  rsel;
  hs_state_e wr_st_q, sn_st_q;
  logic accept_wr, accept_rd;
  logic wr_ack_s, snap_ack_s;
  logic wr_req_q, wr_hi_q;
  logic [DATA_W-1:0] wr_data_q;
  logic sn_req_q, rd_pend_q, rd_armed_q, rd_valid_q;
  logic [TIME_W-1:0] copy_q;
  logic [DATA_W-1:0] rd_hi_q, rd_data_q;

  assign rsel      = reg_sel_e'(rd_sel_i);
  assign accept_wr = wr_en_i & ~busy_o;
  assign accept_rd = rd_req_i & ~busy_o & ~wr_en_i;

  assign cmp_we_o   = accept_wr & wr_sel_i[1];
  assign cmp_hi_o   = wr_sel_i[0];
  assign cmp_data_o = wr_data_i;

  xmt_sync #(.STAGES(SYNC_STAGES)) u_wr_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(x_wr_ack_i), .q_o(wr_ack_s));
  xmt_sync #(.STAGES(SYNC_STAGES)) u_snap_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(x_snap_ack_i), .q_o(snap_ack_s));

  // time write crossing: data held until ack returns
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_st_q   <= HS_IDLE;
      wr_req_q  <= 1'b0;
      wr_hi_q   <= 1'b0;
      wr_data_q <= '0;
    end else begin
      unique case (wr_st_q)
        HS_IDLE: if (accept_wr && !wr_sel_i[1]) begin
          wr_req_q  <= 1'b1;
          wr_hi_q   <= wr_sel_i[0];
          wr_data_q <= wr_data_i;
          wr_st_q   <= HS_REQ;
        end
        HS_REQ: if (wr_ack_s) begin
          wr_req_q <= 1'b0;
          wr_st_q  <= HS_REL;
        end
        HS_REL: if (!wr_ack_s) wr_st_q <= HS_IDLE;
        default: wr_st_q <= HS_IDLE;
      endcase
    end
  end

  // continuous snapshot loop plus read port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sn_st_q    <= HS_IDLE;
      sn_req_q   <= 1'b0;
      rd_pend_q  <= 1'b0;
      rd_armed_q <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      rd_hi_q    <= '0;
      copy_q     <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      if (accept_rd) begin
        unique case (rsel)
          SEL_TIME_LO: rd_pend_q <= 1'b1;
          SEL_TIME_HI: begin rd_valid_q <= 1'b1; rd_data_q <= rd_hi_q; end
          SEL_CMP_LO:  begin rd_valid_q <= 1'b1; rd_data_q <= cmp_i[DATA_W-1:0]; end
          default:     begin rd_valid_q <= 1'b1; rd_data_q <= cmp_i[TIME_W-1:DATA_W]; end
        endcase
      end
      unique case (sn_st_q)
        HS_IDLE: begin
          sn_req_q   <= 1'b1;
          rd_armed_q <= rd_pend_q;
          sn_st_q    <= HS_REQ;
        end
        HS_REQ: if (snap_ack_s) begin
          sn_req_q <= 1'b0;
          copy_q   <= x_snap_i;
          sn_st_q  <= HS_REL;
          if (rd_armed_q) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= x_snap_i[DATA_W-1:0];
            rd_hi_q    <= x_snap_i[TIME_W-1:DATA_W];
            rd_pend_q  <= 1'b0;
            rd_armed_q <= 1'b0;
          end
        end
        HS_REL: if (!snap_ack_s) begin
          // only a snapshot started after the request may answer it
          sn_req_q   <= 1'b1;
          rd_armed_q <= rd_pend_q;
          sn_st_q    <= HS_REQ;
        end
        default: sn_st_q <= HS_IDLE;
      endcase
    end
  end

  assign busy_o       = (wr_st_q != HS_IDLE) | rd_pend_q;
  assign rd_valid_o   = rd_valid_q;
  assign rd_data_o    = rd_data_q;
  assign time_copy_o  = copy_q;
  assign x_wr_req_o   = wr_req_q;
  assign x_wr_hi_o    = wr_hi_q;
  assign x_wr_data_o  = wr_data_q;
  assign x_snap_req_o = sn_req_q;

  AST_WR_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st_q != HS_IDLE) |=> ($stable(wr_data_q) && $stable(wr_hi_q))); // R3
  AST_WR_DROP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_req_q) |-> $past(wr_ack_s)); // R3
  AST_SNAP_RAISE_AFTER_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sn_req_q) |-> !$past(snap_ack_s)); // R6
endmodule

// File: rtl/xclk_mtimer.sv
`timescale 1ns/1ps
module xclk_mtimer #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TIME_W     = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              ref_rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  input  logic [1:0]        rd_sel_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              irq_o
);
  logic [TIME_W-1:0] cmp, time_copy, snap;
  logic cmp_we, cmp_hi;
  logic [DATA_W-1:0] cmp_data, x_wr_data;
  logic x_wr_req, x_wr_hi, x_wr_ack, x_snap_req, x_snap_ack;

  xmt_cpu_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_cpu (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_req_i(rd_req_i), .rd_sel_i(rd_sel_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .busy_o(busy_o),
    .cmp_i(cmp), .cmp_we_o(cmp_we), .cmp_hi_o(cmp_hi), .cmp_data_o(cmp_data),
    .time_copy_o(time_copy),
    .x_wr_req_o(x_wr_req), .x_wr_hi_o(x_wr_hi), .x_wr_data_o(x_wr_data),
    .x_wr_ack_i(x_wr_ack), .x_snap_req_o(x_snap_req), .x_snap_ack_i(x_snap_ack),
    .x_snap_i(snap));

  xmt_cmp_irq #(.DATA_W(DATA_W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cmp_we), .hi_i(cmp_hi),
    .data_i(cmp_data), .time_i(time_copy), .cmp_o(cmp), .irq_o(irq_o));

  xmt_ref_domain #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ref (
    .ref_clk_i(ref_clk_i), .ref_rst_ni(ref_rst_ni),
    .wr_req_i(x_wr_req), .wr_hi_i(x_wr_hi), .wr_data_i(x_wr_data),
    .wr_ack_o(x_wr_ack), .snap_req_i(x_snap_req), .snap_ack_o(x_snap_ack),
    .snap_o(snap));
endmodule

// File: tb/tb_xclk_mtimer.sv
`timescale 1ns/1ps
module tb_xclk_mtimer;
  localparam logic [1:0] TL = 2'b00, TH = 2'b01, CL = 2'b10, CH = 2'b11;

  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0, ref_rst_n = 1'b0;
  logic wr_en_i = 1'b0, rd_req_i = 1'b0;
  logic [1:0] wr_sel_i = '0, rd_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic rd_valid_o, busy_o, irq_o;
  logic [31:0] rd_data_o;
  logic [63:0] ref_edges;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always #8.5 ref_clk = ~ref_clk;

  always @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) ref_edges <= '0;
    else            ref_edges <= ref_edges + 64'd1;

  xclk_mtimer dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .ref_rst_ni(ref_rst_n),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_req_i(rd_req_i), .rd_sel_i(rd_sel_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .busy_o(busy_o), .irq_o(irq_o));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle_wait();
    int g = 0;
    while (busy_o && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    idle_wait();
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    idle_wait();
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    int g = 0;
    idle_wait();
    rd_req_i = 1'b1; rd_sel_i = sel;
    @(negedge clk);
    rd_req_i = 1'b0;
    while (!rd_valid_o && g < 5000) begin @(negedge clk); g++; end
    if (g >= 5000) chk(1'b0, "read timeout (R5/R6)", 64'(g), 64'd0);
    d = rd_data_o;
    @(negedge clk);
  endtask

  function automatic bit in_win(input logic [63:0] v, input logic [63:0] lo, input logic [63:0] span);
    return (v >= lo) && (v <= lo + span);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1..R8 act=%0d exp=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b, h, x, hh, lo, hi;
    logic [63:0] e0, e1;
    int vcount;
    void'($urandom(32'd715));
    repeat (10) @(negedge clk);
    rst_n = 1'b1; ref_rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq_o == 1'b0, "R1 irq low", 64'(irq_o), 64'd0);
    chk(busy_o == 1'b0, "R1 busy low", 64'(busy_o), 64'd0);
    chk(rd_valid_o == 1'b0, "R1 no valid", 64'(rd_valid_o), 64'd0);
    rd(CL, v); chk(v == 32'hFFFF_FFFF, "R1 cmp lo", 64'(v), 64'hFFFF_FFFF);
    rd(CH, v); chk(v == 32'hFFFF_FFFF, "R1 cmp hi", 64'(v), 64'hFFFF_FFFF);
    rd(TL, v); chk(v != 0 && 64'(v) <= ref_edges, "R1 time from zero", 64'(v), ref_edges);
    rd(TH, v); chk(v == 0, "R1 time hi zero", 64'(v), 64'd0);

    // R2 free running
    e0 = ref_edges; rd(TL, a); rd(TL, b); e1 = ref_edges;
    chk(b > a && 64'(b - a) <= e1 - e0, "R2 monotonic step", 64'(b), 64'(a));

    // R6 / R4 time writes
    for (int i = 0; i < 8; i++) begin
      x = $urandom & 32'h7FFF_FFFF;
      wr(TH, 32'd0);
      e0 = ref_edges; wr(TL, x); rd(TL, v); e1 = ref_edges;
      chk(in_win(64'(v), 64'(x), e1 - e0), "R6 fresh low read", 64'(v), 64'(x));
      rd(TH, h); chk(h == 0, "R4 hi kept on lo write", 64'(h), 64'd0);
      hh = $urandom & 32'h0000_FFFF;
      wr(TH, hh); rd(TL, lo); e1 = ref_edges; rd(TH, hi);
      chk(in_win(64'(lo), 64'(x), e1 - e0), "R4 lo kept on hi write", 64'(lo), 64'(x));
      chk(hi == hh, "R4 hi written", 64'(hi), 64'(hh));
    end

    // R5 / R4 compare
    for (int i = 0; i < 8; i++) begin
      a = $urandom; b = $urandom | 32'h8000_0000;
      wr(CL, a); wr(CH, b);
      rd(CL, v); chk(v == a, "R5 cmp lo readback", 64'(v), 64'(a));
      rd(CH, v); chk(v == b, "R5 cmp hi readback", 64'(v), 64'(b));
      x = $urandom;
      wr(CL, x);
      rd(CH, v); chk(v == b, "R4 cmp hi kept", 64'(v), 64'(b));
      rd(CL, v); chk(v == x, "R5 cmp lo rewrite", 64'(v), 64'(x));
    end

    // R3 refusal while busy
    wr(CL, 32'h1111_2222); wr(CH, 32'h3333_4444);
    wr_en_i = 1'b1; wr_sel_i = TL; wr_data_i = 32'h100;
    @(negedge clk);
    wr_en_i = 1'b0;
    chk(busy_o == 1'b1, "R3 busy after time write", 64'(busy_o), 64'd1);
    wr_en_i = 1'b1; wr_sel_i = CL; wr_data_i = 32'hDEAD_BEEF;
    rd_req_i = 1'b1; rd_sel_i = CL;
    @(negedge clk);
    wr_en_i = 1'b0; rd_req_i = 1'b0;
    vcount = 0;
    while (busy_o) begin
      if (rd_valid_o) vcount++;
      @(negedge clk);
    end
    chk(vcount == 0, "R3 read refused", 64'(vcount), 64'd0);
    rd(CL, v); chk(v == 32'h1111_2222, "R3 write refused", 64'(v), 64'h1111_2222);

    // R7 untorn pair across low wrap
    wr(TL, 32'd0); wr(TH, 32'd5); wr(TL, 32'hFFFF_FFF0);
    rd(TL, lo); rd(TH, hi);
    h = (lo >= 32'hFFFF_FFF0) ? 32'd5 : 32'd6;
    chk(hi == h, "R7 pair consistent", {hi, lo}, 64'(h));
    repeat (1000) @(negedge clk);
    rd(TL, lo); rd(TH, hi);
    chk(hi == 32'd6, "R7 carry into hi", 64'(hi), 64'd6);
    chk(lo < 32'h1000, "R7 low wrapped", 64'(lo), 64'h1000);

    // R8 interrupt
    wr(TL, 32'h100); wr(TH, 32'd0);
    wr(CH, 32'd0); wr(CL, 32'hFFFF_0000);
    repeat (60) @(negedge clk);
    chk(irq_o == 1'b0, "R8 below compare", 64'(irq_o), 64'd0);
    wr(TL, 32'hFFFF_0010);
    repeat (100) @(negedge clk);
    chk(irq_o == 1'b1, "R8 time reached compare", 64'(irq_o), 64'd1);
    wr(CH, 32'd1);
    repeat (2) @(negedge clk);
    chk(irq_o == 1'b0, "R8 drop on compare raise", 64'(irq_o), 64'd0);
    wr(CH, 32'd0); wr(CL, 32'd0);
    repeat (4) @(negedge clk);
    chk(irq_o == 1'b1, "R8 compare zero", 64'(irq_o), 64'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule